// File: doc/BRIEF.md
# RMII Transmit Framer with Frame Check Sequence

This block turns a stream of bare frame bytes into a complete Ethernet transmission on a reduced media-independent transmit port. Frame bytes arrive on a byte-wide valid/ready stream with an end-of-frame marker. The block sends the preamble and the start-of-frame delimiter on its own, then the frame bytes, then the 32-bit CRC it computes over those bytes. The output is one 2-bit symbol per cycle of the 50 MHz reference clock. The upstream buffer therefore stores only the frame payload and never has to produce framing or checksum bytes.

The stream is pulled one byte at a time, exactly when the previous symbol group has almost left the wire. If the upstream source has no byte ready at that moment, the frame is closed early with a checksum over the bytes already sent. After every frame the transmit enable stays low for at least the minimum interframe gap before the next frame may start.

Top module: `rmii_tx_framer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `tx_en` is 0, `tx_d` is 00 and `in_ready` is 0.
- R2: A transmission starts only when `in_valid` is high. Its first 28 symbols are 2'b01, which is seven bytes of 0x55. `tx_en` rises together with the first of these symbols.
- R3: The next 4 symbols after the preamble are 01, 01, 01, 11. This is the delimiter byte 0xD5.
- R4: Each frame byte is sent as 4 symbols, low bit pair first: `tx_d` = byte[1:0], then [3:2], then [5:4], then [7:6].
- R5: After the last frame byte come 16 symbols holding the complement of a CRC-32. The CRC uses generator 0x04C11DB7, a register preset to all ones, and input bits taken low bit first. The checksum is sent low byte first and low bit first, so that the bytes "123456789" yield the transmitted word 0xCBF43926.
- R6: `tx_en` stays high without a break from the first preamble symbol to the last checksum symbol. The frame therefore lasts 4 × (8 + bytes + 4) cycles. While `tx_en` is low, `tx_d` is 00.
- R7: `in_ready` is high for one cycle per accepted byte, on the last symbol of the byte or delimiter before it. It is never high during the preamble, the checksum or the gap, so a frame of N bytes sees exactly N handshakes.
- R8: Between two frames `tx_en` stays low for at least 48 cycles. The gap is exactly 48 cycles when the next frame is already waiting.
- R9: While `in_valid` stays low, `tx_en` stays low.
- R10: If `in_valid` is low when the next byte is due in a frame that has not seen `in_last`, the frame ends at once with the checksum over the bytes already sent.
- R11: The byte accepted with `in_last` high is the final one. No further byte is taken until the next frame, even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | Frame byte present |
| in_last | input | 1 | Present byte is the last of the frame |
| in_ready | output | 1 | Byte accepted at this clock edge when valid |
| tx_en | output | 1 | Transmit enable |
| tx_d | output | 2 | Transmit symbol |

## Verification
The assertions check the following on every cycle:
- `tx_en` always rises with a preamble symbol.
- Every frame lasts a whole number of 4-symbol groups.
- The low time between frames never drops below 48 cycles.
- The ready pulse never lasts two cycles.
- Data symbols step through a byte in order.
- The CRC register changes only when it is cleared or fed a byte.

Some properties only the bench's scenarios can show. These are the exact symbol contents, the checksum value against a known check string, the handshake count per frame, the exact 48-cycle gap on back-to-back frames, and early closure when the source runs dry.

// File: rtl/rmii_txf_pkg.sv
package rmii_txf_pkg;

  localparam int BYTE_W          = 8;
  localparam int SYM_W           = 2;
  localparam int SYMS_PER_BYTE   = BYTE_W / SYM_W;
  localparam int CRC_W           = 32;
  localparam int CRC_BYTES       = CRC_W / BYTE_W;
  localparam logic [CRC_W-1:0] CRC_PRESET    = '1;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

  localparam logic [SYM_W-1:0] SYM_PREAMBLE  = 2'b01;
  localparam logic [SYM_W-1:0] SYM_DELIM_END = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_DATA,
    ST_FCS,
    ST_GAP
  } txf_state_t;

  function automatic logic [CRC_W-1:0] crc_step_byte(
    input logic [CRC_W-1:0]  c_in,
    input logic [BYTE_W-1:0] d
  );
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/rmii_txf_crc.sv
module rmii_txf_crc
  import rmii_txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  crc_q <= CRC_PRESET;
    else if (en)     crc_q <= crc_step_byte(crc_q, data);
  end

  assign crc = crc_q;

  // R5: the running checksum moves only on a clear or an accepted byte
  p_crc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(crc_q));

endmodule

// File: rtl/rmii_txf_seq.sv
module rmii_txf_seq
  import rmii_txf_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int IFG_CLKS  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [CRC_W-1:0]  crc_in,
  output logic              crc_clr,
  output logic              crc_en,
  output txf_state_t        st,
  output logic [1:0]        sym_idx,
  output logic [SYM_W-1:0]  data_sym,
  output logic [SYM_W-1:0]  fcs_sym
);

  localparam int CNT_W = $clog2(PRE_BYTES + CRC_BYTES + 1);
  localparam int GAP_W = $clog2(IFG_CLKS + 1);
  localparam logic [1:0] SYM_LAST = 2'(SYMS_PER_BYTE - 1);

  logic [CNT_W-1:0]  cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [BYTE_W-1:0] byte_sh;
  logic [CRC_W-1:0]  fcs_sh;
  logic              last_q;
  logic              fetch;
  logic              grp_end;

  assign grp_end  = (sym_idx == SYM_LAST);
  assign in_ready = grp_end && ((st == ST_SFD) || (st == ST_DATA && !last_q));
  assign fetch    = in_ready && in_valid;
  assign crc_clr  = (st == ST_IDLE) && in_valid;
  assign crc_en   = fetch;
  assign data_sym = byte_sh[SYM_W-1:0];
  assign fcs_sym  = fcs_sh[SYM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sym_idx <= '0;
      cnt     <= '0;
      gap_cnt <= '0;
      byte_sh <= '0;
      fcs_sh  <= '0;
      last_q  <= 1'b0;
    end else begin
      sym_idx <= (st == ST_IDLE || st == ST_GAP) ? 2'd0 : sym_idx + 2'd1;
      byte_sh <= byte_sh >> SYM_W;
      fcs_sh  <= fcs_sh >> SYM_W;
      if (fetch) begin
        byte_sh <= in_data;
        last_q  <= in_last;
      end
      case (st)
        ST_IDLE: if (in_valid) begin
          st  <= ST_PRE;
          cnt <= '0;
        end
        ST_PRE: if (grp_end) begin
          if (cnt == CNT_W'(PRE_BYTES - 1)) begin
            st  <= ST_SFD;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SFD: if (grp_end) begin
          if (in_valid) begin
            st <= ST_DATA;
          end else begin
            st     <= ST_FCS;
            fcs_sh <= ~crc_in;
          end
        end
        ST_DATA: if (grp_end && !fetch) begin
          st     <= ST_FCS;
          fcs_sh <= ~crc_in;
          cnt    <= '0;
        end
        ST_FCS: if (grp_end) begin
          if (cnt == CNT_W'(CRC_BYTES - 1)) begin
            st      <= ST_GAP;
            gap_cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(IFG_CLKS - 2)) st <= ST_IDLE;
          else                                 gap_cnt <= gap_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: data symbols advance one position per cycle inside a byte
  p_sym_step_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && sym_idx != SYM_LAST) |=>
      (st == ST_DATA && sym_idx == $past(sym_idx) + 2'd1));

  // R7: at most one acceptance per byte slot
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  // R11: the marked final byte hands over to the checksum
  p_last_closes_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && last_q && grp_end) |=> (st == ST_FCS));

endmodule

// File: rtl/rmii_txf_out.sv
module rmii_txf_out
  import rmii_txf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  txf_state_t       st,
  input  logic [1:0]       sym_idx,
  input  logic [SYM_W-1:0] data_sym,
  input  logic [SYM_W-1:0] fcs_sym,
  output logic             tx_en,
  output logic [SYM_W-1:0] tx_d
);

  logic             busy;
  logic [SYM_W-1:0] sym;

  always_comb begin
    busy = 1'b1;
    sym  = '0;
    case (st)
      ST_PRE:  sym = SYM_PREAMBLE;
      ST_SFD:  sym = (sym_idx == 2'(SYMS_PER_BYTE - 1)) ? SYM_DELIM_END : SYM_PREAMBLE;
      ST_DATA: sym = data_sym;
      ST_FCS:  sym = fcs_sym;
      default: busy = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en <= 1'b0;
      tx_d  <= '0;
    end else begin
      tx_en <= busy;
      tx_d  <= busy ? sym : '0;
    end
  end

  // R6: an idle line carries the zero symbol
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> (tx_d == '0));

endmodule

// File: rtl/rmii_tx_framer.sv
module rmii_tx_framer
  import rmii_txf_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int IFG_CLKS  = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       tx_en,
  output logic [1:0] tx_d
);

  localparam int LOW_W = $clog2(IFG_CLKS + 1) + 1;

  txf_state_t       st;
  logic [1:0]       sym_idx;
  logic [SYM_W-1:0] data_sym;
  logic [SYM_W-1:0] fcs_sym;
  logic [CRC_W-1:0] crc;
  logic             crc_clr;
  logic             crc_en;

  rmii_txf_seq #(
    .PRE_BYTES (PRE_BYTES),
    .IFG_CLKS  (IFG_CLKS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .crc_in   (crc),
    .crc_clr  (crc_clr),
    .crc_en   (crc_en),
    .st       (st),
    .sym_idx  (sym_idx),
    .data_sym (data_sym),
    .fcs_sym  (fcs_sym)
  );

  rmii_txf_crc u_crc (
    .clk  (clk),
    .rst  (rst),
    .clr  (crc_clr),
    .en   (crc_en),
    .data (in_data),
    .crc  (crc)
  );

  rmii_txf_out u_out (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .sym_idx  (sym_idx),
    .data_sym (data_sym),
    .fcs_sym  (fcs_sym),
    .tx_en    (tx_en),
    .tx_d     (tx_d)
  );

  logic [LOW_W-1:0] low_run;
  logic             sent_q;
  logic [1:0]       grp_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
      sent_q  <= 1'b0;
      grp_run <= '0;
    end else if (tx_en) begin
      low_run <= '0;
      sent_q  <= 1'b1;
      grp_run <= grp_run + 2'd1;
    end else begin
      grp_run <= '0;
      if (low_run != '1) low_run <= low_run + 1'b1;
    end
  end

  // R2: enable rises with a preamble symbol
  p_first_sym_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> (tx_d == SYM_PREAMBLE));

  // R6: a frame spans whole symbol groups
  p_whole_groups_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> (grp_run == 2'd0));

  // R8: minimum idle time between frames
  p_min_gap_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_en) && sent_q) |-> (low_run >= LOW_W'(IFG_CLKS)));

endmodule

// File: tb/rmii_tx_framer_bench.sv
module rmii_tx_framer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       tx_en;
  logic [1:0] tx_d;

  always #2 clk = ~clk;

  rmii_tx_framer u_rmii_tx_framer (
    .clk      (clk),
    .rst      (rst),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .tx_en    (tx_en),
    .tx_d     (tx_d)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // line monitor
  logic [1:0] cap  [0:511];
  logic [1:0] snap [0:511];
  int cap_n = 0, snap_n = 0, snap_hs = 0, hs_cnt = 0;
  int frames_done = 0, rises = 0, low_run = 0, last_gap = 0, bad_idle = 0;
  bit prev_en = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_en) begin
        if (!prev_en) begin
          cap_n = 0;
          hs_cnt = 0;
          last_gap = low_run;
          rises++;
        end
        if (cap_n < 512) cap[cap_n] = tx_d;
        cap_n++;
        low_run = 0;
      end else begin
        if (tx_d != 2'b00) bad_idle++;
        low_run++;
        if (prev_en) begin
          for (int i = 0; i < 512; i++) snap[i] = cap[i];
          snap_n = cap_n;
          snap_hs = hs_cnt;
          frames_done++;
        end
      end
      if (in_valid && in_ready) hs_cnt++;
      prev_en = tx_en;
    end
  end

  logic [7:0] fb [0:63];

  // forward-form checksum; transmitted bit k is the complement of c[31-k]
  function automatic logic [31:0] ref_fcs_word(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] w;
    logic b;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        b = c[31] ^ fb[i][k];
        c = c << 1;
        if (b) c = c ^ 32'h04C11DB7;
      end
    for (int k = 0; k < 32; k++) w[k] = ~c[31-k];
    return w;
  endfunction

  function automatic logic [31:0] snap_fcs_word(input int n);
    logic [31:0] w;
    for (int j = 0; j < 16; j++) w[2*j +: 2] = snap[32 + 4*n + j];
    return w;
  endfunction

  task automatic send_frame(input int n, input bit with_last);
    for (int i = 0; i < n; i++) begin
      in_data  = fb[i];
      in_valid = 1'b1;
      in_last  = with_last && (i == n - 1);
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_frames(input int k);
    while (frames_done < k) @(negedge clk);
  endtask

  task automatic check_frame(input int n, input string tag);
    int bad_i;
    logic [1:0] e;
    check(snap_n == 48 + 4*n, {"R6 frame length ", tag}, snap_n, 48 + 4*n);
    if (snap_n != 48 + 4*n) return;
    bad_i = -1;
    for (int i = 0; i < 28; i++) if (snap[i] != 2'b01 && bad_i < 0) bad_i = i;
    check(bad_i < 0, {"R2 preamble ", tag}, bad_i < 0 ? 1 : snap[bad_i], 1);
    check(snap[28] == 2'b01 && snap[29] == 2'b01 && snap[30] == 2'b01 && snap[31] == 2'b11,
          {"R3 delimiter ", tag}, {snap[28], snap[29], snap[30], snap[31]}, 8'b01010111);
    bad_i = -1;
    e = '0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 4; j++)
        if (bad_i < 0 && snap[32 + 4*i + j] != fb[i][2*j +: 2]) begin
          bad_i = 32 + 4*i + j;
          e = fb[i][2*j +: 2];
        end
    check(bad_i < 0, {"R4 data symbols ", tag}, bad_i < 0 ? 0 : snap[bad_i], e);
    check(snap_fcs_word(n) == ref_fcs_word(n), {"R5 checksum ", tag},
          snap_fcs_word(n), ref_fcs_word(n));
    check(snap_hs == n, {"R7 handshakes ", tag}, snap_hs, n);
  endtask

  // vector: {bytes[7:0], seed[7:0], expected symbols[11:0]}
  localparam int NV = 6;
  localparam logic [27:0] VEC [0:NV-1] = '{
    {8'd1,  8'h00, 12'd52},
    {8'd2,  8'hFF, 12'd56},
    {8'd5,  8'h3C, 12'd68},
    {8'd7,  8'h80, 12'd76},
    {8'd16, 8'hA5, 12'd112},
    {8'd60, 8'h11, 12'd288}
  };

  initial begin
    int done;
    string s;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_en == 1'b0 && tx_d == 2'b00 && in_ready == 1'b0, "R1 in reset",
          {tx_en, tx_d, in_ready}, 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(tx_en == 1'b0 && tx_d == 2'b00 && in_ready == 1'b0, "R1 after release",
          {tx_en, tx_d, in_ready}, 0);

    // R9: nothing offered, nothing sent
    repeat (100) @(negedge clk);
    check(rises == 0 && tx_en == 1'b0, "R9 idle without valid", rises, 0);

    for (int v = 0; v < NV; v++) begin
      int n;
      n = int'(VEC[v][27:20]);
      for (int i = 0; i < 64; i++) fb[i] = VEC[v][19:12] ^ 8'(i * 29 + 7);
      done = frames_done;
      send_frame(n, 1'b1);
      wait_frames(done + 1);
      s = $sformatf("vector %0d", v);
      check(snap_n == int'(VEC[v][11:0]), {"R6 table length ", s}, snap_n, VEC[v][11:0]);
      check_frame(n, s);
      if (v > 0) check(last_gap >= 48, {"R8 gap ", s}, last_gap, 48);
    end

    // R5: known check string
    for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
    done = frames_done;
    send_frame(9, 1'b1);
    wait_frames(done + 1);
    check_frame(9, "check string");
    check(snap_fcs_word(9) == 32'hCBF43926, "R5 check string word", snap_fcs_word(9), 32'hCBF43926);

    // R8 and R11: second frame waits with valid high during the first one's tail
    for (int i = 0; i < 64; i++) fb[i] = 8'hC3 ^ 8'(i * 11);
    done = frames_done;
    send_frame(3, 1'b1);
    send_frame(3, 1'b1);
    check(frames_done == done + 1, "R11 one frame ended before second taken", frames_done - done, 1);
    check_frame(3, "back-to-back first");
    check(snap_hs == 3, "R11 no extra byte after last", snap_hs, 3);
    wait_frames(done + 2);
    check_frame(3, "back-to-back second");
    check(last_gap == 48, "R8 exact gap with waiting frame", last_gap, 48);

    // R10: source runs dry after four bytes
    for (int i = 0; i < 64; i++) fb[i] = 8'h5A + 8'(i * 3);
    done = frames_done;
    send_frame(4, 1'b0);
    wait_frames(done + 1);
    check_frame(4, "R10 underrun");

    check(bad_idle == 0, "R6 zero symbol while idle", bad_idle, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule